// File: doc/BRIEF.md
# SPI Slave Transmitter with Underrun Recovery

This block is the transmit half of an SPI slave port. The host loads a 24-bit word into a holding register. When the external master starts a word, that word moves into a shift register and goes out on MISO, most significant bit first. SCK idles low. The clock-phase input selects the timing:

- Phase 0 starts a word when SS is asserted. MISO changes on falling SCK edges and the master samples it on rising edges.
- Phase 1 starts a word on the first rising SCK edge after SS is asserted. MISO changes on rising edges and the master samples it on falling edges.

A word starts with the holding register empty is an underrun. In that case the block sets a sticky underrun flag and sends the previous word again. The block has two request outputs that tell the host to supply data:

- The regular request is raised while the holding register is empty and the flag is clear.
- The underrun request is raised while the holding register is empty and the flag is set.

The host clears the flag by reading the status port and then writing a new word. A stop input also clears it. SCK and SS are brought into the system clock domain through a synchronizer before any edge is detected.

Top module: `spi_txu_top`

## Requirements
- R1: A host write (`wr_en_i`) loads `wr_data_i` and marks the holding register full. Starting a word with the holding register full moves its contents to the shift register and marks it empty.
- R2: Words are 24 bits, sent most significant bit first. MISO is driven low whenever SS (`ss_ni`, active low) is deasserted.
- R3: With `cpha_i`=0, the word is loaded when SS is asserted. MISO advances one bit on each falling SCK edge, so the bit read just before rising edge k (k = 0..23) is bit 23-k of the word.
- R4: With `cpha_i`=1, nothing is loaded before the first rising SCK edge. That edge loads the word, and each later rising edge advances MISO one bit, so the bit read after rising edge k is bit 23-k.
- R5: The underrun flag is set when a word starts with the holding register empty. With phase 0 this happens at SS assertion. With phase 1 it happens at the first rising SCK edge and not before.
- R6: On underrun the shift register sends the previously transmitted word again. Before any word has been sent, that word is zero.
- R7: `tx_req_o` equals (holding register empty AND flag clear). `urun_req_o` equals (holding register empty AND flag set).
- R8: The flag clears on a host write that follows a status read (`rd_stat_i`) made while the flag was set. A write with no such earlier read leaves the flag set.
- R9: Asserting `stop_i` clears the underrun flag.
- R10: After reset the flag is clear, the holding register is empty, `tx_req_o` is 1, `urun_req_o` is 0 and MISO is 0. The word that would be resent is zero.
- R11: `stat_o[1]` is the underrun flag and `stat_o[0]` is the holding-register-empty flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpha_i | input | 1 | Clock phase select; change only while SS is deasserted |
| stop_i | input | 1 | Stop state; clears the underrun flag |
| sck_i | input | 1 | Serial clock from the master, idles low |
| ss_ni | input | 1 | Slave select, active low |
| miso_o | output | 1 | Serial data to the master |
| wr_en_i | input | 1 | Host write strobe for the holding register |
| wr_data_i | input | 24 | Host write data |
| rd_stat_i | input | 1 | Host status read strobe |
| stat_o | output | 2 | {underrun flag, holding register empty} |
| tx_req_o | output | 1 | Regular transmit request |
| urun_req_o | output | 1 | Underrun transmit request |

## Verification
Host strobes take effect at the next clock edge, so `stat_o` and both request outputs are sampled on the falling clock edge that follows a write or read pulse. SCK and SS pass through a two-stage synchronizer and then an edge register, so the shift register, MISO and the flag change on the third rising clock edge after a pin changes. The bench acting as master holds every SCK and SS level for six clock cycles and samples MISO and `stat_o` only at the end of each hold. For phase 1, the flag is checked both after SS assertion and after the first rising SCK edge, which separates the two possible set points.

// File: rtl/spi_txu_pkg.sv
package spi_txu_pkg;
  localparam int unsigned TXU_WORD_W = 24;
  localparam int unsigned TXU_SYNC_STAGES = 2;

  typedef enum logic {
    PH_LOAD_ON_SEL  = 1'b0,
    PH_LOAD_ON_EDGE = 1'b1
  } txu_phase_e;

  typedef struct packed {
    logic underrun;
    logic hold_empty;
  } txu_stat_t;
endpackage

// File: rtl/spi_txu_sync.sv
module spi_txu_sync #(
  parameter int unsigned N = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_txu_shift.sv
module spi_txu_shift
  import spi_txu_pkg::*;
#(
  parameter int unsigned WORD_W = TXU_WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_i,
  input  logic              cpha_i,
  input  logic              sck_s_i,
  input  logic              ssn_s_i,
  input  logic              hold_full_i,
  input  logic [WORD_W-1:0] hold_data_i,
  output logic              load_o,
  output logic              underrun_o,
  output logic              miso_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic              sck_d_q, ssn_d_q, busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shift_q, last_q;
  logic              sck_rise, sck_fall, sel, sel_on, start, samp_edge, shift_edge;
  txu_phase_e        ph;

  assign ph       = txu_phase_e'(cpha_i);
  assign sck_rise = sck_s_i & ~sck_d_q;
  assign sck_fall = ~sck_s_i & sck_d_q;
  assign sel      = ~ssn_s_i;
  assign sel_on   = ~ssn_s_i & ssn_d_q;

  // phase 0 starts on select, phase 1 on first rising edge of an idle word
  assign start = ~stop_i & sel & ~busy_q &
                 ((ph == PH_LOAD_ON_SEL) ? sel_on : sck_rise);
  assign samp_edge  = (ph == PH_LOAD_ON_SEL) ? sck_rise : sck_fall;
  assign shift_edge = (ph == PH_LOAD_ON_SEL) ? sck_fall : sck_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d_q <= 1'b0;
      ssn_d_q <= 1'b1;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      shift_q <= '0;
      last_q  <= '0;
    end else begin
      sck_d_q <= sck_s_i;
      ssn_d_q <= ssn_s_i;
      if (stop_i || !sel) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        if (hold_full_i) begin
          shift_q <= hold_data_i;
          last_q  <= hold_data_i;
        end else begin
          shift_q <= last_q;
        end
      end else if (busy_q) begin
        if (shift_edge) shift_q <= {shift_q[WORD_W-2:0], 1'b0};
        if (samp_edge) begin
          if (cnt_q == LAST_BIT) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign load_o     = start & hold_full_i;
  assign underrun_o = start & ~hold_full_i;
  assign miso_o     = sel & shift_q[WORD_W-1];

  // R3
  load_takes_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (shift_q == $past(hold_data_i)));
  // R6
  resend_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> (shift_q == $past(last_q)));
  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && !start |=> $stable(shift_q));
endmodule

// File: rtl/spi_txu_hold.sv
module spi_txu_hold #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              load_i,
  input  logic              flag_i,
  output logic [WORD_W-1:0] hold_o,
  output logic              full_o,
  output logic              tx_req_o,
  output logic              urun_req_o
);
  logic [WORD_W-1:0] hold_q;
  logic              full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (wr_i) begin
      hold_q <= wr_data_i;
      full_q <= 1'b1;
    end else if (load_i) begin
      full_q <= 1'b0;
    end
  end

  assign hold_o     = hold_q;
  assign full_o     = full_q;
  assign tx_req_o   = ~full_q & ~flag_i;
  assign urun_req_o = ~full_q & flag_i;

  // R1
  wr_fills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> full_q);
  // R1
  load_drains_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !wr_i |=> !full_q);
endmodule

// File: rtl/spi_txu_flag.sv
module spi_txu_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_stat_i,
  input  logic wr_i,
  input  logic stop_i,
  output logic flag_o
);
  logic flag_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (stop_i || wr_i)           armed_q <= 1'b0;
      else if (rd_stat_i && flag_q) armed_q <= 1'b1;
      if (stop_i)                   flag_q <= 1'b0;
      else if (set_i)               flag_q <= 1'b1;
      else if (wr_i && armed_q)     flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  // R5
  set_only_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(set_i));
  // R9
  stop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !flag_q);
  // R8
  clear_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> ($past(stop_i) || $past(wr_i)));
endmodule

// File: rtl/spi_txu_top.sv
module spi_txu_top
  import spi_txu_pkg::*;
#(
  parameter int unsigned WORD_W = TXU_WORD_W,
  parameter int unsigned SYNC_STAGES = TXU_SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpha_i,
  input  logic              stop_i,
  input  logic              sck_i,
  input  logic              ss_ni,
  output logic              miso_o,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_stat_i,
  output logic [1:0]        stat_o,
  output logic              tx_req_o,
  output logic              urun_req_o
);
  logic [1:0]        pins_s;
  logic              load, underrun, flag, hold_full;
  logic [WORD_W-1:0] hold_data;
  txu_stat_t         stat;

  spi_txu_sync #(.N(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk_i, .rst_ni, .d_i({ss_ni, sck_i}), .q_o(pins_s)
  );

  spi_txu_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i, .rst_ni, .stop_i, .cpha_i,
    .sck_s_i(pins_s[0]), .ssn_s_i(pins_s[1]),
    .hold_full_i(hold_full), .hold_data_i(hold_data),
    .load_o(load), .underrun_o(underrun), .miso_o
  );

  spi_txu_hold #(.WORD_W(WORD_W)) u_hold (
    .clk_i, .rst_ni, .wr_i(wr_en_i), .wr_data_i, .load_i(load), .flag_i(flag),
    .hold_o(hold_data), .full_o(hold_full), .tx_req_o, .urun_req_o
  );

  spi_txu_flag u_flag (
    .clk_i, .rst_ni, .set_i(underrun), .rd_stat_i, .wr_i(wr_en_i), .stop_i,
    .flag_o(flag)
  );

  assign stat.underrun   = flag;
  assign stat.hold_empty = ~hold_full;
  assign stat_o          = stat;

  // R7
  one_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_req_o && urun_req_o));
endmodule

// File: tb/sim_spi_txu_top.sv
module sim_spi_txu_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpha = 1'b0, stop = 1'b0, sck = 1'b0, ss_n = 1'b1;
  logic wr = 1'b0, rd = 1'b0;
  logic [23:0] wdata = '0;
  logic miso, txr, urr;
  logic [1:0] stat;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model
  logic [23:0] m_hold = '0, m_last = '0;
  bit m_full = 1'b0, m_flag = 1'b0, m_arm = 1'b0;

  always #5 clk = ~clk;

  spi_txu_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpha_i(cpha), .stop_i(stop), .sck_i(sck),
    .ss_ni(ss_n), .miso_o(miso), .wr_en_i(wr), .wr_data_i(wdata),
    .rd_stat_i(rd), .stat_o(stat), .tx_req_o(txr), .urun_req_o(urr)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic hold_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] exp_stat();
    return {m_flag, ~m_full};
  endfunction

  task automatic check_side(input string tag);
    chk(stat == exp_stat(), {tag, " R11 stat"}, 32'(stat), 32'(exp_stat()));
    chk(txr == (!m_full && !m_flag), {tag, " R7 tx_req"}, 32'(txr), 32'(!m_full && !m_flag));
    chk(urr == (!m_full && m_flag), {tag, " R7 urun_req"}, 32'(urr), 32'(!m_full && m_flag));
  endtask

  task automatic host_wr(input logic [23:0] d);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    if (m_arm) m_flag = 1'b0;
    m_arm = 1'b0; m_hold = d; m_full = 1'b1;
  endtask

  task automatic host_rd();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    if (m_flag) m_arm = 1'b1;
  endtask

  task automatic xfer(input logic ph, input string tag);
    logic [23:0] got, exp;
    bit flag_before;
    got = '0;
    flag_before = m_flag;
    if (m_full) begin exp = m_hold; m_last = m_hold; m_full = 1'b0; end
    else begin exp = m_last; m_flag = 1'b1; end
    cpha = ph;
    hold_clk(1);
    ss_n = 1'b0;
    hold_clk(6);
    if (!ph) chk(stat[1] == m_flag, {tag, " R5 flag at select, phase 0"}, 32'(stat[1]), 32'(m_flag));
    else     chk(stat[1] == flag_before, {tag, " R5 flag unchanged before edge, phase 1"}, 32'(stat[1]), 32'(flag_before));
    for (int i = 0; i < 24; i++) begin
      if (!ph) begin
        got[23-i] = miso;
        sck = 1'b1; hold_clk(6);
        sck = 1'b0; hold_clk(6);
      end else begin
        sck = 1'b1; hold_clk(6);
        if (i == 0) chk(stat[1] == m_flag, {tag, " R5 flag at first edge, phase 1"}, 32'(stat[1]), 32'(m_flag));
        got[23-i] = miso;
        sck = 1'b0; hold_clk(6);
      end
    end
    ss_n = 1'b1;
    hold_clk(6);
    chk(got == exp, {tag, ph ? " R4 R6 word phase 1" : " R3 R6 word phase 0"}, 32'(got), 32'(exp));
    chk(miso == 1'b0, {tag, " R2 miso low deselected"}, 32'(miso), 32'd0);
    check_side(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    hold_clk(3);
    rst_n = 1'b1;
    hold_clk(2);
    // R10 reset state
    chk(stat == 2'b01, "R10 stat after reset", 32'(stat), 32'h1);
    chk(txr == 1'b1 && urr == 1'b0, "R10 requests after reset", {30'd0, txr, urr}, 32'h2);
    chk(miso == 1'b0, "R10 miso after reset", 32'(miso), 32'd0);

    // R6 underrun before any write resends zero
    xfer(1'b0, "first underrun");

    // R8 write without read keeps flag
    host_wr(24'hA5C3_0F);
    hold_clk(1);
    check_side("R8 write without read");
    xfer(1'b1, "R1 loaded word");
    // R8 read then write clears
    host_rd();
    host_wr(24'h800001);
    hold_clk(1);
    check_side("R8 read then write");
    chk(stat[1] == 1'b0, "R8 flag cleared", 32'(stat[1]), 32'd0);
    xfer(1'b0, "R3 msb/lsb word");
    xfer(1'b1, "R4 R6 resend phase 1");

    // R9 stop clears flag
    stop = 1'b1; hold_clk(1); stop = 1'b0;
    m_flag = 1'b0; m_arm = 1'b0;
    hold_clk(1);
    check_side("R9 stop");

    // R4 phase 1 back-to-back fresh words
    host_wr(24'h123456);
    xfer(1'b1, "R4 phase 1 a");
    host_wr(24'hFEDCBA);
    xfer(1'b1, "R4 phase 1 b");

    for (int k = 0; k < 40; k++) begin
      r = $urandom;
      if (r[1]) host_rd();
      if (r[0]) host_wr(24'($urandom));
      hold_clk(1);
      check_side("random pre");
      xfer(r[2], "random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule